// File: doc/BRIEF.md
# Narrow Deblocking Edge Filter

This block applies the short correction across a block edge to the two pixels on each side of it: the pair just before the edge (outer and inner) and the pair just after it. Eight lines are handled side by side. Each line has its own enable and inner-flat flags from the edge decision stage, and its own high-edge-variance flag. The bit depth select is shared by all lines and chooses between 10-bit and 12-bit samples.

A line is in narrow mode when its enable is set and its inner-flat flag is clear. Only a line in narrow mode has its inner pixels corrected. The outer pixels are corrected only when, in addition, high edge variance is clear. A line in any other mode leaves the block with its four samples unchanged. A new group of lines can be accepted on every cycle. The results appear one registered stage later.

Top module: `narrow_edge_filter`

## Requirements
- R1: `out_valid` rises in the cycle after each cycle in which `in_valid` is high, and is low in the cycle after each cycle in which `in_valid` is low.
- R2: While `in_valid` is low, the four output pixel buses keep their last value, even if the input pixels change.
- R3: A line whose `lane_en` bit is 0, or whose `lane_flat` bit is 1, outputs its four input samples unchanged.
- R4: The outer difference term is clip(p1 - q1) when the line's `lane_hev` bit is 1, and zero when it is 0. Here clip() limits a value to [-2^(bd-1), 2^(bd-1)-1].
- R5: The filter strength is f = clip(3*(q0 - p0) + term). The side steps are f1 = min(f+4, 2^(bd-1)-1) >>> 3 and f2 = min(f+3, 2^(bd-1)-1) >>> 3. Both shifts are arithmetic and round toward minus infinity.
- R6: On a line in narrow mode, the inner outputs are p0 + f2 and q0 - f1. Each is clamped to [0, 2^bd - 1].
- R7: On a line in narrow mode with `lane_hev` = 0, the outer outputs are p1 + g and q1 - g, with g = (f1 + 1) >>> 1, each clamped to [0, 2^bd - 1]. When `lane_hev` = 1, the outer outputs equal p1 and q1.
- R8: `bd_sel` = 0 selects a bit depth of 10 (maximum pixel value 1023). `bd_sel` = 1 selects 12 (maximum 4095).
- R9: Each line's result depends only on that line's samples and flags, together with the shared `bd_sel`.
- R10: During and right after reset, `out_valid` is 0 and all output pixels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A group of lines is presented |
| bd_sel | input | 1 | 0 selects 10-bit samples, 1 selects 12-bit samples |
| lane_en | input | LANES | Per-line filter enable |
| lane_flat | input | LANES | Per-line inner-flat flag |
| lane_hev | input | LANES | Per-line high edge variance flag |
| p1_i | input | LANES x PIX_W | Outer sample before the edge |
| p0_i | input | LANES x PIX_W | Inner sample before the edge |
| q0_i | input | LANES x PIX_W | Inner sample after the edge |
| q1_i | input | LANES x PIX_W | Outer sample after the edge |
| out_valid | output | 1 | Registered results are valid |
| p1_o | output | LANES x PIX_W | Corrected outer sample before the edge |
| p0_o | output | LANES x PIX_W | Corrected inner sample before the edge |
| q0_o | output | LANES x PIX_W | Corrected inner sample after the edge |
| q1_o | output | LANES x PIX_W | Corrected outer sample after the edge |

## Verification
The bench builds the block with its defaults: eight lines, 12-bit sample buses, and the two selectable depths of 10 and 12. These values make reachable, on one build, the saturation of the strength at both the 10-bit and the 12-bit signed limits, the clamping of outputs to 0 and to either maximum, and the same stimulus giving different results under the two depths. With eight lines, each group can mix filtered lines with bypassed neighbours, so the bench can check that the lines are independent.

// File: rtl/nf_pkg.sv
package nf_pkg;

    typedef enum logic {
        DEPTH_LOW  = 1'b0,
        DEPTH_HIGH = 1'b1
    } depth_e;

    function automatic int signed_top(input int bits);
        return (1 << (bits - 1)) - 1;
    endfunction

    function automatic int pixel_top(input int bits);
        return (1 << bits) - 1;
    endfunction

endpackage

// File: rtl/nf_sclip.sv
module nf_sclip #(
    parameter int W     = 16,
    parameter int BD_LO = 10,
    parameter int BD_HI = 12
) (
    input  logic                depth,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);
    import nf_pkg::*;

    localparam logic signed [W-1:0] TOP_LO = W'(signed_top(BD_LO));
    localparam logic signed [W-1:0] TOP_HI = W'(signed_top(BD_HI));

    logic signed [W-1:0] top_v;
    logic signed [W-1:0] bot_v;

    always_comb begin
        top_v = (depth_e'(depth) == DEPTH_HIGH) ? TOP_HI : TOP_LO;
        bot_v = -top_v - W'(1);
        if (x > top_v)      y = top_v;
        else if (x < bot_v) y = bot_v;
        else                y = x;
    end
endmodule

// File: rtl/nf_uclamp.sv
module nf_uclamp #(
    parameter int W     = 16,
    parameter int PIX_W = 12,
    parameter int BD_LO = 10,
    parameter int BD_HI = 12
) (
    input  logic                depth,
    input  logic signed [W-1:0] x,
    output logic [PIX_W-1:0]    y
);
    import nf_pkg::*;

    localparam logic signed [W-1:0] PMAX_LO = W'(pixel_top(BD_LO));
    localparam logic signed [W-1:0] PMAX_HI = W'(pixel_top(BD_HI));
    localparam logic signed [W-1:0] ZERO_S  = '0;

    logic signed [W-1:0] pmax_v;
    logic signed [W-1:0] sat_v;

    always_comb begin
        pmax_v = (depth_e'(depth) == DEPTH_HIGH) ? PMAX_HI : PMAX_LO;
        if (x < ZERO_S)      sat_v = ZERO_S;
        else if (x > pmax_v) sat_v = pmax_v;
        else                 sat_v = x;
        y = sat_v[PIX_W-1:0];
    end
endmodule

// File: rtl/nf_lane.sv
module nf_lane #(
    parameter int PIX_W = 12,
    parameter int BD_LO = 10,
    parameter int BD_HI = 12
) (
    input  logic             depth,
    input  logic             en,
    input  logic             flat,
    input  logic             hev,
    input  logic [PIX_W-1:0] p1,
    input  logic [PIX_W-1:0] p0,
    input  logic [PIX_W-1:0] q0,
    input  logic [PIX_W-1:0] q1,
    output logic [PIX_W-1:0] p1_n,
    output logic [PIX_W-1:0] p0_n,
    output logic [PIX_W-1:0] q0_n,
    output logic [PIX_W-1:0] q1_n
);
    import nf_pkg::*;

    // PIX_W+4 bits hold 3*(q0-p0) plus a clipped term with headroom
    localparam int W = PIX_W + 4;
    localparam int EXT = W - PIX_W;
    localparam logic signed [W-1:0] TOP_LO = W'(signed_top(BD_LO));
    localparam logic signed [W-1:0] TOP_HI = W'(signed_top(BD_HI));
    localparam logic signed [W-1:0] K_ONE   = W'(1);
    localparam logic signed [W-1:0] K_THREE = W'(3);
    localparam logic signed [W-1:0] K_FOUR  = W'(4);
    localparam logic signed [W-1:0] ZERO_S  = '0;

    logic signed [W-1:0] sp1, sp0, sq0, sq1;
    logic signed [W-1:0] outer_raw, outer_clip, outer_term;
    logic signed [W-1:0] step_diff, str_raw, str_clip;
    logic signed [W-1:0] top_v, add4, add3, f1_v, f2_v, g_v;
    logic signed [W-1:0] p0_sum, q0_sum, p1_sum, q1_sum;
    logic [PIX_W-1:0]    p0_c, q0_c, p1_c, q1_c;
    logic                narrow, outer_upd;

    always_comb begin
        sp1 = $signed({{EXT{1'b0}}, p1});
        sp0 = $signed({{EXT{1'b0}}, p0});
        sq0 = $signed({{EXT{1'b0}}, q0});
        sq1 = $signed({{EXT{1'b0}}, q1});
        outer_raw = sp1 - sq1;
    end

    nf_sclip #(.W(W), .BD_LO(BD_LO), .BD_HI(BD_HI)) i_clip_outer (
        .depth (depth),
        .x     (outer_raw),
        .y     (outer_clip)
    );

    always_comb begin
        outer_term = hev ? outer_clip : ZERO_S;
        step_diff  = sq0 - sp0;
        str_raw    = (step_diff <<< 1) + step_diff + outer_term;
    end

    nf_sclip #(.W(W), .BD_LO(BD_LO), .BD_HI(BD_HI)) i_clip_str (
        .depth (depth),
        .x     (str_raw),
        .y     (str_clip)
    );

    always_comb begin
        top_v = (depth_e'(depth) == DEPTH_HIGH) ? TOP_HI : TOP_LO;
        add4  = str_clip + K_FOUR;
        add3  = str_clip + K_THREE;
        if (add4 > top_v) add4 = top_v;
        if (add3 > top_v) add3 = top_v;
        f1_v   = add4 >>> 3;
        f2_v   = add3 >>> 3;
        g_v    = (f1_v + K_ONE) >>> 1;
        p0_sum = sp0 + f2_v;
        q0_sum = sq0 - f1_v;
        p1_sum = sp1 + g_v;
        q1_sum = sq1 - g_v;
    end

    nf_uclamp #(.W(W), .PIX_W(PIX_W), .BD_LO(BD_LO), .BD_HI(BD_HI)) i_sat_p0 (
        .depth (depth), .x (p0_sum), .y (p0_c)
    );
    nf_uclamp #(.W(W), .PIX_W(PIX_W), .BD_LO(BD_LO), .BD_HI(BD_HI)) i_sat_q0 (
        .depth (depth), .x (q0_sum), .y (q0_c)
    );
    nf_uclamp #(.W(W), .PIX_W(PIX_W), .BD_LO(BD_LO), .BD_HI(BD_HI)) i_sat_p1 (
        .depth (depth), .x (p1_sum), .y (p1_c)
    );
    nf_uclamp #(.W(W), .PIX_W(PIX_W), .BD_LO(BD_LO), .BD_HI(BD_HI)) i_sat_q1 (
        .depth (depth), .x (q1_sum), .y (q1_c)
    );

    always_comb begin
        narrow    = en && !flat;
        outer_upd = narrow && !hev;
        p0_n = narrow    ? p0_c : p0;
        q0_n = narrow    ? q0_c : q0;
        p1_n = outer_upd ? p1_c : p1;
        q1_n = outer_upd ? q1_c : q1;
    end
endmodule

// File: rtl/narrow_edge_filter.sv
module narrow_edge_filter #(
    parameter int LANES = 8,
    parameter int PIX_W = 12,
    parameter int BD_LO = 10,
    parameter int BD_HI = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        bd_sel,
    input  logic [LANES-1:0]            lane_en,
    input  logic [LANES-1:0]            lane_flat,
    input  logic [LANES-1:0]            lane_hev,
    input  logic [LANES-1:0][PIX_W-1:0] p1_i,
    input  logic [LANES-1:0][PIX_W-1:0] p0_i,
    input  logic [LANES-1:0][PIX_W-1:0] q0_i,
    input  logic [LANES-1:0][PIX_W-1:0] q1_i,
    output logic                        out_valid,
    output logic [LANES-1:0][PIX_W-1:0] p1_o,
    output logic [LANES-1:0][PIX_W-1:0] p0_o,
    output logic [LANES-1:0][PIX_W-1:0] q0_o,
    output logic [LANES-1:0][PIX_W-1:0] q1_o
);
    import nf_pkg::*;

    localparam logic [PIX_W-1:0] PMAX_LO = PIX_W'(pixel_top(BD_LO));

    typedef struct packed {
        logic                        vld;
        logic [LANES-1:0][PIX_W-1:0] p1;
        logic [LANES-1:0][PIX_W-1:0] p0;
        logic [LANES-1:0][PIX_W-1:0] q0;
        logic [LANES-1:0][PIX_W-1:0] q1;
    } stage_t;

    stage_t stage_d, stage_q;
    logic [LANES-1:0][PIX_W-1:0] p1_n, p0_n, q0_n, q1_n;

    for (genvar li = 0; li < LANES; li++) begin : g_lane
        nf_lane #(.PIX_W(PIX_W), .BD_LO(BD_LO), .BD_HI(BD_HI)) i_lane (
            .depth (bd_sel),
            .en    (lane_en[li]),
            .flat  (lane_flat[li]),
            .hev   (lane_hev[li]),
            .p1    (p1_i[li]),
            .p0    (p0_i[li]),
            .q0    (q0_i[li]),
            .q1    (q1_i[li]),
            .p1_n  (p1_n[li]),
            .p0_n  (p0_n[li]),
            .q0_n  (q0_n[li]),
            .q1_n  (q1_n[li])
        );

        // R3: bypassed lines leave the block untouched
        p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !(lane_en[li] && !lane_flat[li])) |=>
            (p1_o[li] == $past(p1_i[li]) && p0_o[li] == $past(p0_i[li]) &&
             q0_o[li] == $past(q0_i[li]) && q1_o[li] == $past(q1_i[li])));

        // R7: high edge variance keeps the outer pair
        p_outer_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_hev[li]) |=>
            (p1_o[li] == $past(p1_i[li]) && q1_o[li] == $past(q1_i[li])));

        // R6: 10-bit filtered results never exceed the 10-bit maximum
        p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !bd_sel && lane_en[li] && !lane_flat[li]) |=>
            (p0_o[li] <= PMAX_LO && q0_o[li] <= PMAX_LO));
    end

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.p1 = p1_n;
            stage_d.p0 = p0_n;
            stage_d.q0 = q0_n;
            stage_d.q1 = q1_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.vld;
    assign p1_o      = stage_q.p1;
    assign p0_o      = stage_q.p0;
    assign q0_o      = stage_q.q0;
    assign q1_o      = stage_q.q1;

    // R1: one-cycle latency of the valid flag
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: results hold while no group is presented
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(p1_o) && $stable(p0_o) && $stable(q0_o) && $stable(q1_o)));
endmodule

// File: tb/test_narrow_edge_filter.sv
`timescale 1ns/1ps
module test_narrow_edge_filter;
    localparam int LANES = 8;
    localparam int PIX_W = 12;
    localparam int NV    = 13;

    typedef struct packed {
        logic bd, en, flat, hev;
        logic [11:0] p1, p0, q0, q1;
        logic [11:0] ep1, ep0, eq0, eq1;
    } vec_t;

    // fields: bd en flat hev | p1 p0 q0 q1 | expected p1 p0 q0 q1
    localparam vec_t TABLE [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0, 12'd100,12'd100,12'd110,12'd110, 12'd102,12'd104,12'd106,12'd108}, // R7 R6 basic
        '{1'b0,1'b1,1'b0,1'b1, 12'd100,12'd100,12'd110,12'd110, 12'd100,12'd102,12'd107,12'd110}, // R4 term used
        '{1'b0,1'b1,1'b0,1'b0, 12'd500,12'd500,12'd300,12'd300, 12'd468,12'd436,12'd364,12'd332}, // R5 neg saturation
        '{1'b0,1'b1,1'b0,1'b0, 12'd0,  12'd0,  12'd400,12'd400, 12'd32, 12'd63, 12'd337,12'd368}, // R5 pos saturation
        '{1'b0,1'b1,1'b0,1'b1, 12'd1023,12'd0, 12'd20, 12'd0,   12'd1023,12'd63,12'd0,  12'd0},   // R6 clamp to 0
        '{1'b0,1'b1,1'b0,1'b1, 12'd0,  12'd1020,12'd1000,12'd1023, 12'd0,12'd956,12'd1023,12'd1023}, // R6 clamp high
        '{1'b1,1'b1,1'b0,1'b0, 12'd2000,12'd2000,12'd2100,12'd2100, 12'd2019,12'd2037,12'd2062,12'd2081}, // R8 12-bit
        '{1'b1,1'b1,1'b0,1'b1, 12'd4095,12'd0, 12'd1000,12'd0,  12'd4095,12'd255,12'd745,12'd0},  // R8 12-bit limits
        '{1'b1,1'b1,1'b0,1'b0, 12'd0,  12'd0,  12'd400,12'd400, 12'd75, 12'd150,12'd250,12'd325}, // R8 vs entry 3
        '{1'b0,1'b0,1'b0,1'b0, 12'd100,12'd100,12'd110,12'd110, 12'd100,12'd100,12'd110,12'd110}, // R3 disabled
        '{1'b0,1'b1,1'b1,1'b0, 12'd100,12'd100,12'd110,12'd110, 12'd100,12'd100,12'd110,12'd110}, // R3 flat
        '{1'b0,1'b1,1'b0,1'b0, 12'd50, 12'd50, 12'd49, 12'd49,  12'd50, 12'd50, 12'd49, 12'd49},  // R5 small step
        '{1'b0,1'b1,1'b0,1'b0, 12'd52, 12'd52, 12'd50, 12'd50,  12'd52, 12'd51, 12'd51, 12'd50}   // R5 floor shift
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic bd_sel = 1'b0;
    logic [LANES-1:0] lane_en = '0, lane_flat = '0, lane_hev = '0;
    logic [LANES-1:0][PIX_W-1:0] p1_i = '0, p0_i = '0, q0_i = '0, q1_i = '0;
    logic out_valid;
    logic [LANES-1:0][PIX_W-1:0] p1_o, p0_o, q0_o, q1_o;

    int checks = 0;
    int errors = 0;
    logic [LANES-1:0][4*PIX_W-1:0] exp_q;

    always #10 clk = ~clk;

    narrow_edge_filter i_narrow_edge_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bd_sel(bd_sel),
        .lane_en(lane_en), .lane_flat(lane_flat), .lane_hev(lane_hev),
        .p1_i(p1_i), .p0_i(p0_i), .q0_i(q0_i), .q1_i(q1_i),
        .out_valid(out_valid), .p1_o(p1_o), .p0_o(p0_o), .q0_o(q0_o), .q1_o(q1_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // even lanes filter entry j; odd lanes carry entry j+1 with enable cleared (R9 R3)
    task automatic drive_entry(input int j);
        vec_t a, b;
        a = TABLE[j];
        b = TABLE[(j + 1) % NV];
        in_valid = 1'b1;
        bd_sel   = a.bd;
        for (int k = 0; k < LANES; k++) begin
            if (k % 2 == 0) begin
                lane_en[k] = a.en; lane_flat[k] = a.flat; lane_hev[k] = a.hev;
                p1_i[k] = a.p1; p0_i[k] = a.p0; q0_i[k] = a.q0; q1_i[k] = a.q1;
                exp_q[k] = {a.ep1, a.ep0, a.eq0, a.eq1};
            end else begin
                lane_en[k] = 1'b0; lane_flat[k] = b.flat; lane_hev[k] = b.hev;
                p1_i[k] = b.p1; p0_i[k] = b.p0; q0_i[k] = b.q0; q1_i[k] = b.q1;
                exp_q[k] = {b.p1, b.p0, b.q0, b.q1};
            end
        end
    endtask

    task automatic check_lanes(input int j, input logic [LANES-1:0][4*PIX_W-1:0] expv);
        for (int k = 0; k < LANES; k++) begin
            if (k % 2 == 0)
                check($sformatf("R5 R6 R7 entry %0d lane %0d", j, k),
                      64'({p1_o[k], p0_o[k], q0_o[k], q1_o[k]}), 64'(expv[k]));
            else
                check($sformatf("R9 R3 entry %0d lane %0d", j, k),
                      64'({p1_o[k], p0_o[k], q0_o[k], q1_o[k]}), 64'(expv[k]));
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [LANES-1:0][4*PIX_W-1:0] prev_exp;
        logic [LANES-1:0][PIX_W-1:0] held_p0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 out_valid in reset", 64'(out_valid), 64'd0);
        check("R10 pixels in reset", 64'(p0_o ^ q0_o ^ p1_o ^ q1_o) | 64'(|p0_o), 64'd0);
        rst_n = 1'b1;
        step();
        check("R10 out_valid after reset", 64'(out_valid), 64'd0);

        // table walked back to back; result of entry j checked one cycle later (R1 R4 R8)
        prev_exp = '0;
        for (int j = 0; j < NV; j++) begin
            drive_entry(j);
            prev_exp = exp_q;
            step();
            check("R1 out_valid after valid", 64'(out_valid), 64'd1);
            check_lanes(j, prev_exp);
        end

        // R1: valid low gives out_valid low next cycle
        // R2: outputs hold while inputs change with valid low
        held_p0 = p0_o;
        in_valid = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            p0_i[k] = 12'd7; q0_i[k] = 12'd900; lane_en[k] = 1'b1; lane_flat[k] = 1'b0;
        end
        step();
        check("R1 out_valid after idle", 64'(out_valid), 64'd0);
        check("R2 p0 held", 64'(p0_o), 64'(held_p0));
        step();
        check("R2 outputs held two idle cycles", 64'(p0_o), 64'(held_p0));
        check_lanes(NV - 1, prev_exp);

        // R8: same stimulus, both depths, single cycle pulse
        drive_entry(3);
        step();
        check_lanes(3, exp_q);
        drive_entry(8);
        step();
        check_lanes(8, exp_q);
        in_valid = 1'b0;
        step();
        check("R1 single pulse ends", 64'(out_valid), 64'd0);

        finish_run();
    end
endmodule